// File: doc/BRIEF.md
# Banked-Stack Register File with Reset-Vector Loader

This block keeps the architectural state of a 32-bit processor core: eight data registers, seven general address registers, a supervisor stack pointer, a user stack pointer, a 16-bit status word, a program counter and a vector base register. An execution unit reads and writes registers through sized, typed ports. Address register index 7 is not stored anywhere. Each access to it goes to one of the two stack pointers, chosen by the live supervisor bit of the status word.

After reset the block sits in a start-up state. The first step request starts the boot sequence. It fetches the initial supervisor stack pointer and then the initial program counter from memory, and only then reports that it is running. All memory traffic goes through one valid/ready port that is 16 bits wide. Each 32-bit quantity moves as two beats. The block also accepts a push of a 32-bit value onto the active stack through a valid/ready push port. A halt input parks the block in a halted state, and only reset leaves that state.

The memory port is valid/ready. Once the block raises `bus_valid_o`, it holds that signal, together with the address, the write flag and the write data, until a cycle in which `bus_ready_i` is high. That cycle completes the beat. Read data is taken in the same cycle. The push port accepts a value in any cycle where `push_valid_i` and `push_ready_o` are both high.

Top module: `arch_state_core`

## Requirements
- R1: Reset sets the status word to 0x2700. It clears the program counter, both stack pointers, the vector base and every data and address register. Both `running_o` and `halted_o` read 0 after reset.
- R2: In the start-up state the block makes no memory access until a step request arrives. After the step it reads the longword at byte address 0 into the supervisor stack pointer and then the longword at byte address 4 into the program counter. `running_o` rises only after the last beat of the second read. A step request made while running has no effect and causes no bus traffic.
- R3: Each 32-bit access is two 16-bit beats. The first beat carries bits 31:16 at the base address and the second carries bits 15:0 at base+2.
- R4: While `bus_valid_o` is high and `bus_ready_i` is low, the next cycle keeps `bus_valid_o` high with the same address, write flag and write data.
- R5: Register type 1 (address) with index 7 reads and writes the supervisor stack pointer when status bit 13 is 1, and the user stack pointer when it is 0.
- R6: Write sizes are encoded 0 = byte, 1 = word, 2 = long. A byte write replaces bits 7:0, a word write replaces bits 15:0, and a long write replaces all 32 bits. Bits that are not replaced keep their value. Type 0 selects data registers and type 1 selects address registers.
- R7: A read with size 0, 1 or 2 returns the register masked to 8, 16 or 32 bits, zero-extended.
- R8: An accepted push lowers the active stack pointer by 4 in the next cycle. It then writes the value, high half first, at the new stack pointer and at the new stack pointer plus 2. `push_ready_o` is high only while running with no memory transfer in flight.
- R9: `halt_i` while running moves the block to the halted state. There `halted_o` stays 1 and `running_o` stays 0 until reset, step requests are ignored, and `push_ready_o` is 0.
- R10: The status word, program counter and vector base each load their full width from their own write port in the cycle after the write enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_i | input | 1 | Step request; starts the boot fetch when in the start-up state |
| halt_i | input | 1 | Enter the halted state when running |
| running_o | output | 1 | Boot fetch is done and the block is running |
| halted_o | output | 1 | Block is halted |
| rd_type_i | input | 1 | Read register type: 0 data, 1 address |
| rd_idx_i | input | 3 | Read register index |
| rd_size_i | input | 2 | Read size: 0 byte, 1 word, 2 long |
| rd_data_o | output | 32 | Zero-extended read value |
| wr_en_i | input | 1 | Register write enable |
| wr_type_i | input | 1 | Write register type: 0 data, 1 address |
| wr_idx_i | input | 3 | Write register index |
| wr_size_i | input | 2 | Write size: 0 byte, 1 word, 2 long |
| wr_data_i | input | 32 | Write value |
| sr_we_i | input | 1 | Status word write enable |
| sr_wdata_i | input | 16 | Status word write value |
| sr_o | output | 16 | Status word |
| pc_we_i | input | 1 | Program counter write enable |
| pc_wdata_i | input | 32 | Program counter write value |
| pc_o | output | 32 | Program counter |
| vbr_we_i | input | 1 | Vector base write enable |
| vbr_wdata_i | input | 32 | Vector base write value |
| vbr_o | output | 32 | Vector base |
| ssp_o | output | 32 | Supervisor stack pointer |
| usp_o | output | 32 | User stack pointer |
| push_valid_i | input | 1 | Push request valid |
| push_ready_o | output | 1 | Push request can be accepted |
| push_data_i | input | 32 | Value to push |
| bus_valid_o | output | 1 | Memory beat request valid |
| bus_ready_i | input | 1 | Memory beat acknowledge |
| bus_write_o | output | 1 | Beat is a write |
| bus_addr_o | output | 32 | Beat byte address |
| bus_wdata_o | output | 16 | Beat write data |
| bus_rdata_i | input | 16 | Beat read data, valid with acknowledge |

## Verification
The register ports are swept over every type, every index and every write size. For each combination a known background longword is written first and then overlaid with a sized value. The result is read back at all three sizes, which separates a wrong merge mask from a wrong read mask. Index 7 of the address registers is written and read with the supervisor bit cleared and then set, and both stack-pointer outputs are compared, so misrouting shows up as a wrong value on one of them. The boot fetch and the pushes are run with zero, one and two wait states on the memory side. The bench compares the recorded beat addresses and the memory contents against big-endian splitting, which exposes swapped halves, a missing decrement and any failure to hold the request under back-pressure.

// File: rtl/arch_state_pkg.sv
package arch_state_pkg;

  localparam int XLEN        = 32;
  localparam int BUS_W       = 16;
  localparam int SR_W        = 16;
  localparam logic [SR_W-1:0] SR_RESET = 16'h2700;
  localparam int SUP_BIT     = 13;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2
  } opsize_e;

  typedef enum logic [1:0] {
    RS_INIT = 2'd0,
    RS_RUN  = 2'd1,
    RS_HALT = 2'd2
  } run_e;

  function automatic logic [XLEN-1:0] size_mask(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: size_mask = XLEN'(32'h0000_00FF);
      SZ_WORD: size_mask = XLEN'(32'h0000_FFFF);
      default: size_mask = '1;
    endcase
  endfunction

  function automatic logic [XLEN-1:0] sized_merge(input logic [XLEN-1:0] old_v,
                                                  input logic [XLEN-1:0] new_v,
                                                  input logic [1:0]      sz);
    logic [XLEN-1:0] m;
    m = size_mask(sz);
    sized_merge = (old_v & ~m) | (new_v & m);
  endfunction

endpackage

// File: rtl/long_xfer.sv
module long_xfer #(
  parameter int XLEN  = 32,
  parameter int BUS_W = 16,
  parameter int AW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             write_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [XLEN-1:0]  wdata_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [XLEN-1:0]  rdata_o,
  output logic             bus_valid_o,
  input  logic             bus_ready_i,
  output logic             bus_write_o,
  output logic [AW-1:0]    bus_addr_o,
  output logic [BUS_W-1:0] bus_wdata_o,
  input  logic [BUS_W-1:0] bus_rdata_i
);
  localparam int BEATS   = XLEN / BUS_W;
  localparam int BEAT_W  = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam int BYTE_SH = $clog2(BUS_W / 8);

  logic                  busy_q;
  logic                  write_q;
  logic [AW-1:0]         base_q;
  logic [BEAT_W-1:0]     beat_q;
  logic [XLEN-1:0]       wbuf_q;
  logic [XLEN-BUS_W-1:0] rbuf_q;
  logic                  ack;
  logic                  last;

  assign ack  = busy_q && bus_ready_i;
  assign last = (beat_q == BEAT_W'(BEATS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      write_q <= 1'b0;
      base_q  <= '0;
      beat_q  <= '0;
      wbuf_q  <= '0;
      rbuf_q  <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q  <= 1'b1;
        write_q <= write_i;
        base_q  <= addr_i;
        beat_q  <= '0;
        wbuf_q  <= wdata_i;
      end
    end else if (ack) begin
      wbuf_q <= wbuf_q << BUS_W;
      rbuf_q <= {rbuf_q, bus_rdata_i} >> 0;
      if (last) busy_q <= 1'b0;
      else      beat_q <= beat_q + 1'b1;
    end
  end

  assign busy_o      = busy_q;
  assign done_o      = ack && last;
  assign rdata_o     = {rbuf_q, bus_rdata_i};
  assign bus_valid_o = busy_q;
  assign bus_write_o = write_q;
  assign bus_addr_o  = base_q + (AW'(beat_q) << BYTE_SH);
  assign bus_wdata_o = wbuf_q[XLEN-1 -: BUS_W];

endmodule

// File: rtl/gpr_bank.sv
module gpr_bank
  import arch_state_pkg::*;
#(
  parameter int NDREG = 8,
  parameter int NAREG = 8,
  parameter int IDX_W = 3,
  parameter int SP_STEP = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sup_i,
  input  logic            rd_type_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  input  logic [1:0]      rd_size_i,
  output logic [XLEN-1:0] rd_data_o,
  input  logic            wr_en_i,
  input  logic            wr_type_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [1:0]      wr_size_i,
  input  logic [XLEN-1:0] wr_data_i,
  input  logic            boot_sp_we_i,
  input  logic [XLEN-1:0] boot_sp_i,
  input  logic            push_dec_i,
  output logic [XLEN-1:0] active_sp_o,
  output logic [XLEN-1:0] ssp_o,
  output logic [XLEN-1:0] usp_o
);
  localparam int NREAL = NAREG - 1;
  localparam logic [IDX_W-1:0] SP_IDX = IDX_W'(NAREG - 1);

  logic [XLEN-1:0] dreg [NDREG];
  logic [XLEN-1:0] areg [NREAL];
  logic [XLEN-1:0] ssp_q, usp_q;
  logic [XLEN-1:0] raw;
  logic            sp_wr;

  for (genvar i = 0; i < NDREG; i++) begin : g_dreg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        dreg[i] <= '0;
      else if (wr_en_i && !wr_type_i && wr_idx_i == IDX_W'(i))
        dreg[i] <= sized_merge(dreg[i], wr_data_i, wr_size_i);
    end
  end

  for (genvar i = 0; i < NREAL; i++) begin : g_areg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        areg[i] <= '0;
      else if (wr_en_i && wr_type_i && wr_idx_i == IDX_W'(i))
        areg[i] <= sized_merge(areg[i], wr_data_i, wr_size_i);
    end
  end

  assign sp_wr = wr_en_i && wr_type_i && (wr_idx_i == SP_IDX);

  // Stack pointers: boot load, then push decrement, then register-port write.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ssp_q <= '0;
      usp_q <= '0;
    end else if (boot_sp_we_i) begin
      ssp_q <= boot_sp_i;
    end else if (push_dec_i) begin
      if (sup_i) ssp_q <= ssp_q - XLEN'(SP_STEP);
      else       usp_q <= usp_q - XLEN'(SP_STEP);
    end else if (sp_wr) begin
      if (sup_i) ssp_q <= sized_merge(ssp_q, wr_data_i, wr_size_i);
      else       usp_q <= sized_merge(usp_q, wr_data_i, wr_size_i);
    end
  end

  assign active_sp_o = sup_i ? ssp_q : usp_q;

  always_comb begin
    if (!rd_type_i)             raw = dreg[rd_idx_i];
    else if (rd_idx_i == SP_IDX) raw = active_sp_o;
    else                        raw = areg[rd_idx_i];
    rd_data_o = raw & size_mask(rd_size_i);
  end

  assign ssp_o = ssp_q;
  assign usp_o = usp_q;

endmodule

// File: rtl/boot_seq.sv
module boot_seq
  import arch_state_pkg::*;
#(
  parameter int AW = 32,
  parameter logic [AW-1:0] SP_VEC = '0,
  parameter logic [AW-1:0] PC_VEC = AW'(4)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_i,
  input  logic          halt_i,
  input  logic          xfer_done_i,
  output run_e          state_o,
  output logic          xfer_start_o,
  output logic [AW-1:0] xfer_addr_o,
  output logic          load_sp_o,
  output logic          load_pc_o
);
  typedef enum logic [2:0] {
    PH_IDLE, PH_SP_REQ, PH_SP_WAIT, PH_PC_REQ, PH_PC_WAIT
  } phase_e;

  run_e   state_q;
  phase_e phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RS_INIT;
      phase_q <= PH_IDLE;
    end else begin
      case (state_q)
        RS_INIT: begin
          case (phase_q)
            PH_IDLE:    if (step_i) phase_q <= PH_SP_REQ;
            PH_SP_REQ:  phase_q <= PH_SP_WAIT;
            PH_SP_WAIT: if (xfer_done_i) phase_q <= PH_PC_REQ;
            PH_PC_REQ:  phase_q <= PH_PC_WAIT;
            PH_PC_WAIT: if (xfer_done_i) begin
              phase_q <= PH_IDLE;
              state_q <= RS_RUN;
            end
            default:    phase_q <= PH_IDLE;
          endcase
        end
        RS_RUN:  if (halt_i) state_q <= RS_HALT;
        RS_HALT: state_q <= RS_HALT;
        default: state_q <= RS_INIT;
      endcase
    end
  end

  assign state_o      = state_q;
  assign xfer_start_o = (state_q == RS_INIT) &&
                        (phase_q == PH_SP_REQ || phase_q == PH_PC_REQ);
  assign xfer_addr_o  = (phase_q == PH_PC_REQ) ? PC_VEC : SP_VEC;
  assign load_sp_o    = (phase_q == PH_SP_WAIT) && xfer_done_i;
  assign load_pc_o    = (phase_q == PH_PC_WAIT) && xfer_done_i;

endmodule

// File: rtl/arch_state_core.sv
module arch_state_core
  import arch_state_pkg::*;
#(
  parameter int NDREG = 8,
  parameter int NAREG = 8,
  parameter int IDX_W = 3,
  parameter int AW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  input  logic             halt_i,
  output logic             running_o,
  output logic             halted_o,
  input  logic             rd_type_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  input  logic [1:0]       rd_size_i,
  output logic [XLEN-1:0]  rd_data_o,
  input  logic             wr_en_i,
  input  logic             wr_type_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [1:0]       wr_size_i,
  input  logic [XLEN-1:0]  wr_data_i,
  input  logic             sr_we_i,
  input  logic [SR_W-1:0]  sr_wdata_i,
  output logic [SR_W-1:0]  sr_o,
  input  logic             pc_we_i,
  input  logic [XLEN-1:0]  pc_wdata_i,
  output logic [XLEN-1:0]  pc_o,
  input  logic             vbr_we_i,
  input  logic [XLEN-1:0]  vbr_wdata_i,
  output logic [XLEN-1:0]  vbr_o,
  output logic [XLEN-1:0]  ssp_o,
  output logic [XLEN-1:0]  usp_o,
  input  logic             push_valid_i,
  output logic             push_ready_o,
  input  logic [XLEN-1:0]  push_data_i,
  output logic             bus_valid_o,
  input  logic             bus_ready_i,
  output logic             bus_write_o,
  output logic [AW-1:0]    bus_addr_o,
  output logic [BUS_W-1:0] bus_wdata_o,
  input  logic [BUS_W-1:0] bus_rdata_i
);
  localparam int SP_STEP = XLEN / 8;

  run_e            run_state;
  logic            boot_start, load_sp, load_pc;
  logic [AW-1:0]   boot_addr;
  logic            xfer_busy, xfer_done;
  logic [XLEN-1:0] xfer_rdata;
  logic [XLEN-1:0] active_sp;
  logic            push_acc;
  logic [SR_W-1:0] sr_q;
  logic [XLEN-1:0] pc_q, vbr_q;

  boot_seq #(.AW(AW), .SP_VEC(AW'(0)), .PC_VEC(AW'(SP_STEP))) u_boot (
    .clk(clk), .rst_n(rst_n), .step_i(step_i), .halt_i(halt_i),
    .xfer_done_i(xfer_done), .state_o(run_state),
    .xfer_start_o(boot_start), .xfer_addr_o(boot_addr),
    .load_sp_o(load_sp), .load_pc_o(load_pc)
  );

  assign running_o    = (run_state == RS_RUN);
  assign halted_o     = (run_state == RS_HALT);
  assign push_ready_o = running_o && !xfer_busy;
  assign push_acc     = push_valid_i && push_ready_o;

  long_xfer #(.XLEN(XLEN), .BUS_W(BUS_W), .AW(AW)) u_xfer (
    .clk(clk), .rst_n(rst_n),
    .start_i(boot_start || push_acc),
    .write_i(push_acc),
    .addr_i(push_acc ? AW'(active_sp - XLEN'(SP_STEP)) : boot_addr),
    .wdata_i(push_data_i),
    .busy_o(xfer_busy), .done_o(xfer_done), .rdata_o(xfer_rdata),
    .bus_valid_o(bus_valid_o), .bus_ready_i(bus_ready_i),
    .bus_write_o(bus_write_o), .bus_addr_o(bus_addr_o),
    .bus_wdata_o(bus_wdata_o), .bus_rdata_i(bus_rdata_i)
  );

  gpr_bank #(.NDREG(NDREG), .NAREG(NAREG), .IDX_W(IDX_W), .SP_STEP(SP_STEP)) u_bank (
    .clk(clk), .rst_n(rst_n), .sup_i(sr_q[SUP_BIT]),
    .rd_type_i(rd_type_i), .rd_idx_i(rd_idx_i), .rd_size_i(rd_size_i),
    .rd_data_o(rd_data_o),
    .wr_en_i(wr_en_i), .wr_type_i(wr_type_i), .wr_idx_i(wr_idx_i),
    .wr_size_i(wr_size_i), .wr_data_i(wr_data_i),
    .boot_sp_we_i(load_sp), .boot_sp_i(xfer_rdata),
    .push_dec_i(push_acc), .active_sp_o(active_sp),
    .ssp_o(ssp_o), .usp_o(usp_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= SR_RESET;
      pc_q  <= '0;
      vbr_q <= '0;
    end else begin
      if (sr_we_i)      sr_q <= sr_wdata_i;
      if (load_pc)      pc_q <= xfer_rdata;
      else if (pc_we_i) pc_q <= pc_wdata_i;
      if (vbr_we_i)     vbr_q <= vbr_wdata_i;
    end
  end

  assign sr_o  = sr_q;
  assign pc_o  = pc_q;
  assign vbr_o = vbr_q;

endmodule

// File: rtl/arch_state_checker.sv
module arch_state_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        running_o,
  input logic        halted_o,
  input logic [15:0] sr_o,
  input logic [31:0] ssp_o,
  input logic [31:0] usp_o,
  input logic        push_valid_i,
  input logic        push_ready_o,
  input logic        bus_valid_o,
  input logic        bus_ready_i,
  input logic        bus_write_o,
  input logic [31:0] bus_addr_o,
  input logic [15:0] bus_wdata_o
);
  // R4
  a_r4_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid_o && !bus_ready_i |=> bus_valid_o && $stable(bus_addr_o) &&
                                    $stable(bus_write_o) && $stable(bus_wdata_o));

  // R2
  a_r2_run_after_pc_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running_o) |-> $past(bus_valid_o && bus_ready_i && bus_addr_o == 32'h6));

  // R9
  a_r9_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    halted_o |=> halted_o && !running_o);

  // R9
  a_r9_no_push_when_halted: assert property (@(posedge clk) disable iff (!rst_n)
    halted_o |-> !push_ready_o);

  // R8
  a_r8_push_decrements_ssp: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid_i && push_ready_o && sr_o[13] |=> ssp_o == $past(ssp_o) - 32'd4);

  // R8
  a_r8_push_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid_i && push_ready_o |=> bus_valid_o && bus_write_o &&
      bus_addr_o == ($past(sr_o[13]) ? $past(ssp_o) : $past(usp_o)) - 32'd4);

endmodule

bind arch_state_core arch_state_checker u_chk (
  .clk(clk), .rst_n(rst_n), .running_o(running_o), .halted_o(halted_o),
  .sr_o(sr_o), .ssp_o(ssp_o), .usp_o(usp_o),
  .push_valid_i(push_valid_i), .push_ready_o(push_ready_o),
  .bus_valid_o(bus_valid_o), .bus_ready_i(bus_ready_i),
  .bus_write_o(bus_write_o), .bus_addr_o(bus_addr_o), .bus_wdata_o(bus_wdata_o)
);

// File: tb/arch_state_core_test.sv
`timescale 1ns/1ps
module arch_state_core_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic step_i = 0, halt_i = 0;
  logic running_o, halted_o;
  logic rd_type_i = 0; logic [2:0] rd_idx_i = 0; logic [1:0] rd_size_i = 2;
  logic [31:0] rd_data_o;
  logic wr_en_i = 0, wr_type_i = 0; logic [2:0] wr_idx_i = 0; logic [1:0] wr_size_i = 2;
  logic [31:0] wr_data_i = 0;
  logic sr_we_i = 0; logic [15:0] sr_wdata_i = 0; logic [15:0] sr_o;
  logic pc_we_i = 0; logic [31:0] pc_wdata_i = 0, pc_o;
  logic vbr_we_i = 0; logic [31:0] vbr_wdata_i = 0, vbr_o;
  logic [31:0] ssp_o, usp_o;
  logic push_valid_i = 0, push_ready_o; logic [31:0] push_data_i = 0;
  logic bus_valid_o, bus_write_o; logic bus_ready_i = 1'b0;
  logic [31:0] bus_addr_o; logic [15:0] bus_wdata_o; logic [15:0] bus_rdata_i = 16'h0;

  int vectors = 0, fails = 0;
  int wait_lim = 0, wait_cnt = 0;
  int nlog = 0;
  logic [31:0] alog [0:31];
  logic [15:0] mem [0:127];

  always #2.5 clk = ~clk;

  arch_state_core uut (.*);

  // Memory responder: acknowledges after wait_lim idle cycles, acts at negedge.
  always @(negedge clk) begin
    if (bus_ready_i) bus_ready_i = 1'b0;
    else if (bus_valid_o) begin
      if (wait_cnt < wait_lim) wait_cnt++;
      else begin
        wait_cnt = 0;
        bus_ready_i = 1'b1;
        bus_rdata_i = mem[bus_addr_o[7:1]];
        if (bus_write_o) mem[bus_addr_o[7:1]] = bus_wdata_o;
        alog[nlog % 32] = bus_addr_o;
        nlog++;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wreg(input logic t, input int idx, input int sz, input logic [31:0] v);
    @(negedge clk);
    wr_en_i = 1; wr_type_i = t; wr_idx_i = 3'(idx); wr_size_i = 2'(sz); wr_data_i = v;
    @(negedge clk);
    wr_en_i = 0;
  endtask

  task automatic rreg(input logic t, input int idx, input int sz, output logic [31:0] v);
    rd_type_i = t; rd_idx_i = 3'(idx); rd_size_i = 2'(sz);
    #0.5;
    v = rd_data_o;
  endtask

  task automatic set_sr(input logic [15:0] v);
    @(negedge clk); sr_we_i = 1; sr_wdata_i = v;
    @(negedge clk); sr_we_i = 0;
  endtask

  task automatic boot_and_wait;
    @(negedge clk); step_i = 1;
    @(negedge clk); step_i = 0;
    for (int k = 0; k < 100 && !running_o; k++) @(negedge clk);
  endtask

  task automatic do_push(input logic [31:0] v, input logic [31:0] exp_sp, input bit sup);
    @(negedge clk);
    for (int k = 0; k < 100 && !push_ready_o; k++) @(negedge clk);
    push_valid_i = 1; push_data_i = v;
    @(negedge clk);
    push_valid_i = 0;
    chk("R8 stack pointer after push", sup ? ssp_o : usp_o, exp_sp);
    for (int k = 0; k < 100 && !push_ready_o; k++) @(negedge clk);
    @(negedge clk);
  endtask

  function automatic logic [31:0] msk(input int sz);
    return sz == 0 ? 32'hFF : sz == 1 ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [31:0] v, base, val, expw;
    int n0;
    for (int i = 0; i < 128; i++) mem[i] = 16'h0;
    mem[0] = 16'h0000; mem[1] = 16'h0080;
    mem[2] = 16'h1234; mem[3] = 16'h5678;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk("R1 status word", {16'h0, sr_o}, 32'h2700);
    chk("R1 pc", pc_o, 0);
    chk("R1 vbr", vbr_o, 0);
    chk("R1 ssp", ssp_o, 0);
    chk("R1 usp", usp_o, 0);
    chk("R1 running/halted", {30'h0, running_o, halted_o}, 0);
    for (int t = 0; t < 2; t++)
      for (int i = 0; i < 8; i++) begin
        rreg(t[0], i, 2, v);
        chk("R1 register clear", v, 0);
      end

    // R2 no traffic before step, then boot
    repeat (6) @(negedge clk);
    chk("R2 no bus before step", nlog, 0);
    wait_lim = 1;
    boot_and_wait;
    chk("R2 running after boot", {31'h0, running_o}, 1);
    chk("R2 ssp from address 0", ssp_o, 32'h80);
    chk("R2 pc from address 4", pc_o, 32'h1234_5678);
    chk("R3 beat count boot", nlog, 4);
    for (int i = 0; i < 4; i++) chk("R3 beat address order", alog[i], 32'(2 * i));

    // R2 step while running ignored
    n0 = nlog;
    @(negedge clk); step_i = 1; @(negedge clk); step_i = 0;
    repeat (6) @(negedge clk);
    chk("R2 step in running no traffic", nlog, n0);
    chk("R2 pc unchanged", pc_o, 32'h1234_5678);

    // R6 / R7 sweep
    for (int t = 0; t < 2; t++)
      for (int i = 0; i < 8; i++)
        for (int sz = 0; sz < 3; sz++) begin
          base = 32'hA5C3_0F96 ^ 32'(t * 8 + i);
          val  = 32'h1357_9BDF + 32'h0101_0101 * i;
          wreg(t[0], i, 2, base);
          wreg(t[0], i, sz, val);
          expw = (base & ~msk(sz)) | (val & msk(sz));
          for (int rs = 0; rs < 3; rs++) begin
            rreg(t[0], i, rs, v);
            chk(rs == 2 ? "R6 sized write merge" : "R7 sized read mask", v, expw & msk(rs));
          end
        end
    wreg(1, 7, 2, 32'h80);

    // R5 stack pointer steering
    chk("R5 ssp restored via A7 supervisor", ssp_o, 32'h80);
    set_sr(16'h0700);
    wreg(1, 7, 2, 32'h40);
    chk("R5 user write reaches usp", usp_o, 32'h40);
    chk("R5 user write leaves ssp", ssp_o, 32'h80);
    rreg(1, 7, 2, v);
    chk("R5 user read of A7", v, 32'h40);
    set_sr(16'h2700);
    rreg(1, 7, 2, v);
    chk("R5 supervisor read of A7", v, 32'h80);

    // R10 full-width loads
    @(negedge clk); pc_we_i = 1; pc_wdata_i = 32'hCAFE_0010;
    vbr_we_i = 1; vbr_wdata_i = 32'h0000_4400;
    @(negedge clk); pc_we_i = 0; vbr_we_i = 0;
    chk("R10 pc write", pc_o, 32'hCAFE_0010);
    chk("R10 vbr write", vbr_o, 32'h0000_4400);
    set_sr(16'hA71F);
    chk("R10 sr write", {16'h0, sr_o}, 32'hA71F);

    // R8 pushes: supervisor, then user, various wait states
    for (int w = 0; w < 3; w++) begin
      wait_lim = w;
      set_sr(16'h2700);
      n0 = nlog;
      do_push(32'hDEAD_BE00 + 32'(w), 32'h80 - 32'(4 * (w + 1)), 1);
      chk("R8 supervisor push high half", {16'h0, mem[(32'h80 - 4 * (w + 1)) >> 1]}, 32'hDEAD);
      chk("R8 supervisor push low half", {16'h0, mem[((32'h80 - 4 * (w + 1)) >> 1) + 1]}, 32'hBE00 + 32'(w));
      chk("R3 push first beat address", alog[n0 % 32], 32'h80 - 32'(4 * (w + 1)));
      chk("R3 push second beat address", alog[(n0 + 1) % 32], 32'h82 - 32'(4 * (w + 1)));
      set_sr(16'h0700);
      do_push(32'hF00D_0000 + 32'(w), 32'h40 - 32'(4 * (w + 1)), 0);
      chk("R8 user push high half", {16'h0, mem[(32'h40 - 4 * (w + 1)) >> 1]}, 32'hF00D);
      chk("R8 user push low half", {16'h0, mem[((32'h40 - 4 * (w + 1)) >> 1) + 1]}, 32'(w));
      chk("R8 user push leaves ssp", ssp_o, 32'h80 - 32'(4 * (w + 1)));
    end

    // R9 halt
    @(negedge clk); halt_i = 1; @(negedge clk); halt_i = 0;
    chk("R9 halted asserted", {30'h0, running_o, halted_o}, 32'h1);
    chk("R9 push not ready", {31'h0, push_ready_o}, 0);
    n0 = nlog;
    @(negedge clk); step_i = 1; push_valid_i = 1; @(negedge clk); step_i = 0; push_valid_i = 0;
    repeat (8) @(negedge clk);
    chk("R9 still halted", {30'h0, running_o, halted_o}, 32'h1);
    chk("R9 no traffic when halted", nlog, n0);

    // R1 again, then boot with two wait states
    rst_n = 0; @(negedge clk); rst_n = 1; @(negedge clk);
    chk("R1 halt cleared by reset", {30'h0, running_o, halted_o}, 0);
    chk("R1 sr after second reset", {16'h0, sr_o}, 32'h2700);
    chk("R1 pc after second reset", pc_o, 0);
    wait_lim = 2;
    mem[2] = 16'h00AB; mem[3] = 16'hCDEF;
    boot_and_wait;
    chk("R2 pc with wait states", pc_o, 32'h00AB_CDEF);
    chk("R2 ssp with wait states", ssp_o, 32'h80);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule